// File: doc/BRIEF.md
# Priority-Table Highest Interrupt Resolver

This block finds, for a 40-source interrupt controller, the highest-ranked pending interrupt of each kind. A table of 40 slots lists source IDs in rank order, and slot 0 ranks highest. It is combined with three per-source bit vectors: pending, enabled and routing. The result is one packed 32-bit word. Its upper half names the winning normal-interrupt (IRQ) source and its lower half names the winning fast-interrupt (FIQ) source. Each half has its own valid flag.

The block is sequential. A one-cycle `start` pulse begins a scan that looks at one table slot per clock. After 40 slots, `done` rises and the word holds its value until the next `start`. The register file that holds the table and the vectors is outside this block. It drives the inputs and must keep them steady while a scan runs.

Top module: `prio_irq_resolver`

## Requirements
- R1: Each 32-bit table slot word carries an enable flag in bit 31 and a source ID in bits 5:0. Bits 30:6 are ignored.
- R2: A slot takes part in the scan only when its enable flag is set and its ID is below 40. A slot whose ID is 40 or more never wins, even when other inputs are all ones.
- R3: When several slots qualify for the same half, the slot with the lowest index wins.
- R4: Source s corresponds to bit s of the `pend`, `enab` and `route_fiq` vectors. A qualifying slot's source is an FIQ candidate when its `pend`, `enab` and `route_fiq` bits are all 1. It is an IRQ candidate when its `pend` and `enab` bits are 1 and its `route_fiq` bit is 0.
- R5: In `result`, bit 31 is the IRQ-winner flag and bits 21:16 hold the IRQ winner's ID. Bit 15 is the FIQ-winner flag and bits 5:0 hold the FIQ winner's ID.
- R6: A half with no candidate reads its flag as 0 and its ID as 63. With no candidates at all, `result` equals 0x003F003F.
- R7: The two halves are resolved independently. A winner in one half never alters the other half.
- R8: `start` clears `done` at the next edge. `done` rises exactly 40 clock cycles after the last `start`. A `start` issued during a scan restarts the scan from slot 0.
- R9: While `done` is high and `start` is low, `result` and `done` do not change, whatever the data inputs do.
- R10: After reset, `done` is 0 and `result` is 0x003F003F.
- R11: Bits 30:22 and 14:6 of `result` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| ent_words | input | 1280 | 40 slot words; slot i occupies bits 32*i+31 : 32*i |
| pend | input | 40 | Pending bit per source |
| enab | input | 40 | Enable bit per source |
| route_fiq | input | 40 | Routing bit per source: 1 selects FIQ, 0 selects IRQ |
| done | output | 1 | High once a scan has finished; held until the next start |
| result | output | 32 | Packed IRQ/FIQ winner word |

## Verification
The bench places slots with out-of-range IDs or a cleared enable flag ahead of a good slot. A design that skipped the range or flag test would name a bogus source or lose the real winner. It checks slots that are valid but pending-only or enabled-only, and slot words with junk in bits 30:6, which a careless decode would treat as part of the ID. It checks FIQ and IRQ winners that come from different slots in the same scan, including one from the upper source bank and one from the last slot. A design that let one half overwrite the other, or that let a later slot displace an earlier one, would show a wrong ID. It also restarts a scan midway and changes the inputs after `done`. A wrong latency count or an unlatched result would show up as an early `done` or a drifting word.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Packed result layout positions (fixed by the consumer of the word)
  localparam int IRQ_FLAG_POS = 31;
  localparam int IRQ_ID_POS   = 16;
  localparam int FIQ_FLAG_POS = 15;
  localparam int FIQ_ID_POS   = 0;
  localparam int RES_W        = 32;

  typedef struct packed {
    logic irq_hit;
    logic fiq_hit;
  } hit_t;
endpackage

// File: rtl/prio_slot_pick.sv
module prio_slot_pick
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int WORD_W = 32,
  parameter int FLAG_B = 31,
  parameter int ID_W   = 6,
  localparam int CNT_W = $clog2(N_SRC)
) (
  input  logic [N_SRC*WORD_W-1:0] ent_words,
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        enab,
  input  logic [N_SRC-1:0]        route_fiq,
  input  logic [CNT_W-1:0]        slot_idx,
  output hit_t                    hit,
  output logic [ID_W-1:0]         hit_id
);
  localparam int SPACE = 1 << ID_W;

  logic [N_SRC-1:0]       slot_flag;
  logic [ID_W-1:0]        slot_id [N_SRC];
  logic [SPACE-1:0]       pend_x, enab_x, route_x;
  logic                   cur_flag, in_range, live;
  logic [ID_W-1:0]        cur_id;

  // Pull only flag and ID out of each slot word
  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    assign slot_flag[g] = ent_words[g*WORD_W + FLAG_B];
    assign slot_id[g]   = ent_words[g*WORD_W +: ID_W];
  end

  // Zero-extend vectors so any ID indexes safely
  assign pend_x  = {{(SPACE-N_SRC){1'b0}}, pend};
  assign enab_x  = {{(SPACE-N_SRC){1'b0}}, enab};
  assign route_x = {{(SPACE-N_SRC){1'b0}}, route_fiq};

  always_comb begin
    cur_flag    = slot_flag[slot_idx];
    cur_id      = slot_id[slot_idx];
    in_range    = (32'(cur_id) < N_SRC);
    live        = cur_flag && in_range && pend_x[cur_id] && enab_x[cur_id];
    hit.fiq_hit = live && route_x[cur_id];
    hit.irq_hit = live && !route_x[cur_id];
    hit_id      = cur_id;
  end
endmodule

// File: rtl/prio_scan_ctrl.sv
module prio_scan_ctrl #(
  parameter int N_SRC = 40,
  localparam int CNT_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] slot_idx,
  output logic             step,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SRC - 1);

  logic             busy_q, busy_d, done_d;
  logic [CNT_W-1:0] idx_d;

  always_comb begin
    busy_d = busy_q;
    done_d = done;
    idx_d  = slot_idx;
    if (start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      idx_d  = '0;
    end else if (busy_q) begin
      if (slot_idx == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        idx_d  = '0;
      end else begin
        idx_d  = slot_idx + 1'b1;
      end
    end
  end

  assign step = busy_q && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done     <= 1'b0;
      slot_idx <= '0;
    end else begin
      busy_q   <= busy_d;
      done     <= done_d;
      slot_idx <= idx_d;
    end
  end
endmodule

// File: rtl/prio_winner_acc.sv
module prio_winner_acc
  import prio_irq_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  hit_t             hit,
  input  logic [ID_W-1:0]  hit_id,
  output logic [RES_W-1:0] result
);
  localparam int PAD_W = 15 - ID_W;

  logic            irq_v_q, irq_v_d, fiq_v_q, fiq_v_d;
  logic [ID_W-1:0] irq_id_q, irq_id_d, fiq_id_q, fiq_id_d;
  logic            irq_en, fiq_en;

  always_comb begin
    irq_v_d  = irq_v_q;
    irq_id_d = irq_id_q;
    fiq_v_d  = fiq_v_q;
    fiq_id_d = fiq_id_q;
    irq_en   = clear || (step && hit.irq_hit && !irq_v_q);
    fiq_en   = clear || (step && hit.fiq_hit && !fiq_v_q);
    if (clear) begin
      irq_v_d  = 1'b0;
      irq_id_d = '1;
      fiq_v_d  = 1'b0;
      fiq_id_d = '1;
    end else begin
      if (irq_en) begin
        irq_v_d  = 1'b1;
        irq_id_d = hit_id;
      end
      if (fiq_en) begin
        fiq_v_d  = 1'b1;
        fiq_id_d = hit_id;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_v_q  <= 1'b0;
      irq_id_q <= '1;
    end else if (irq_en) begin
      irq_v_q  <= irq_v_d;
      irq_id_q <= irq_id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_v_q  <= 1'b0;
      fiq_id_q <= '1;
    end else if (fiq_en) begin
      fiq_v_q  <= fiq_v_d;
      fiq_id_q <= fiq_id_d;
    end
  end

  assign result = {irq_v_q, {PAD_W{1'b0}}, irq_id_q,
                   fiq_v_q, {PAD_W{1'b0}}, fiq_id_q};
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int WORD_W = 32,
  parameter int FLAG_B = 31,
  parameter int ID_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_SRC*WORD_W-1:0] ent_words,
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        enab,
  input  logic [N_SRC-1:0]        route_fiq,
  output logic                    done,
  output logic [31:0]             result
);
  localparam int CNT_W = $clog2(N_SRC);

  logic [CNT_W-1:0] slot_idx;
  logic             step;
  hit_t             hit;
  logic [ID_W-1:0]  hit_id;

  prio_scan_ctrl #(.N_SRC(N_SRC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .slot_idx(slot_idx), .step(step), .done(done)
  );

  prio_slot_pick #(.N_SRC(N_SRC), .WORD_W(WORD_W), .FLAG_B(FLAG_B), .ID_W(ID_W)) pick_i (
    .ent_words(ent_words), .pend(pend), .enab(enab), .route_fiq(route_fiq),
    .slot_idx(slot_idx), .hit(hit), .hit_id(hit_id)
  );

  prio_winner_acc #(.ID_W(ID_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(step),
    .hit(hit), .hit_id(hit_id), .result(result)
  );
endmodule

// File: rtl/prio_irq_resolver_chk.sv
module prio_irq_resolver_chk #(
  parameter int N_SRC = 40,
  parameter int ID_W  = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic [31:0] result
);
  logic [15:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_start <= '0;
    else if (start)                 since_start <= 16'd1;
    else if (since_start != '0 && since_start != 16'hFFFF)
                                    since_start <= since_start + 16'd1;
  end

  // R8: start drops done
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R8: done rises exactly N_SRC cycles after the last start
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (since_start == 16'(N_SRC + 1)));

  // R9: finished result is frozen until the next start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(result) && done));

  // R11: unnamed bits stay zero
  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (result[30:16+ID_W] == '0) && (result[14:ID_W] == '0));

  // R6: an empty half reads ID all ones
  a_r6_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !result[31] |-> (result[16 +: ID_W] == '1));
  a_r6_fiq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !result[15] |-> (result[0 +: ID_W] == '1));

  // R2: a flagged winner always names an in-range source
  a_r2_irq_range: assert property (@(posedge clk) disable iff (!rst_n)
    result[31] |-> (32'(result[16 +: ID_W]) < N_SRC));
  a_r2_fiq_range: assert property (@(posedge clk) disable iff (!rst_n)
    result[15] |-> (32'(result[0 +: ID_W]) < N_SRC));
endmodule

bind prio_irq_resolver prio_irq_resolver_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result)
);

// File: tb/prio_irq_resolver_tb_top.sv
module prio_irq_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;

  typedef struct packed {
    logic [5:0]  i0; logic [31:0] w0;
    logic [5:0]  i1; logic [31:0] w1;
    logic [5:0]  i2; logic [31:0] w2;
    logic [39:0] pend;
    logic [39:0] enab;
    logic [39:0] route;
    logic [31:0] expv;
  } vec_t;

  localparam logic [31:0] V = 32'h8000_0000;
  localparam logic [39:0] ONE = 40'd1;
  localparam logic [39:0] ALL = 40'hFF_FFFF_FFFF;

  // index 63 marks an unused slot field
  localparam vec_t VECS [12] = '{
    // R6 nothing enabled in the table
    '{6'd63, 32'd0, 6'd63, 32'd0, 6'd63, 32'd0, ALL, ALL, 40'd0, 32'h003F_003F},
    // R4/R5 single IRQ winner
    '{6'd0, V|5, 6'd63, 32'd0, 6'd63, 32'd0, ONE<<5, ONE<<5, 40'd0, 32'h8005_003F},
    // R4/R5 single FIQ winner
    '{6'd3, V|7, 6'd63, 32'd0, 6'd63, 32'd0, ONE<<7, ONE<<7, ONE<<7, 32'h003F_8007},
    // R7 both halves, FIQ from upper bank
    '{6'd2, V|10, 6'd5, V|33, 6'd63, 32'd0, (ONE<<10)|(ONE<<33), (ONE<<10)|(ONE<<33), ONE<<33, 32'h800A_8021},
    // R3 lower slot wins over higher slot
    '{6'd1, V|12, 6'd4, V|3, 6'd63, 32'd0, (ONE<<12)|(ONE<<3), (ONE<<12)|(ONE<<3), 40'd0, 32'h800C_003F},
    // R2 out-of-range ID ahead of a good slot
    '{6'd0, V|45, 6'd6, V|8, 6'd63, 32'd0, ALL, ALL, 40'd0, 32'h8008_003F},
    // R1 cleared flag ahead of a good slot
    '{6'd0, 32'd9, 6'd2, V|11, 6'd63, 32'd0, ALL, ALL, 40'd0, 32'h800B_003F},
    // R4 pending but not enabled
    '{6'd0, V|4, 6'd1, V|6, 6'd63, 32'd0, (ONE<<4)|(ONE<<6), ONE<<6, 40'd0, 32'h8006_003F},
    // R4 enabled but not pending; FIQ ID 39
    '{6'd0, V|4, 6'd7, V|39, 6'd63, 32'd0, ONE<<39, (ONE<<4)|(ONE<<39), ONE<<39, 32'h003F_8027},
    // R3 last slot still reached
    '{6'd39, V|20, 6'd63, 32'd0, 6'd63, 32'd0, ONE<<20, ONE<<20, 40'd0, 32'h8014_003F},
    // R1 junk in bits 30:6
    '{6'd0, 32'hFFFF_FFC2, 6'd63, 32'd0, 6'd63, 32'd0, ONE<<2, ONE<<2, 40'd0, 32'h8002_003F},
    // R7/R3 two FIQ slots and one IRQ slot
    '{6'd8, V|1, 6'd9, V|0, 6'd10, V|2, 40'h7, 40'h7, 40'h3, 32'h8002_8001}
  };

  logic            clk, rst_n, start, done;
  logic [N*32-1:0] ent_words;
  logic [N-1:0]    pend, enab, route_fiq;
  logic [31:0]     result;
  int              n_chk, n_fail;

  prio_irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ent_words(ent_words),
    .pend(pend), .enab(enab), .route_fiq(route_fiq),
    .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic load(input vec_t v);
    ent_words = '0;
    if (v.i0 != 6'd63) ent_words[32*v.i0 +: 32] = v.w0;
    if (v.i1 != 6'd63) ent_words[32*v.i1 +: 32] = v.w1;
    if (v.i2 != 6'd63) ent_words[32*v.i2 +: 32] = v.w2;
    pend = v.pend; enab = v.enab; route_fiq = v.route;
  endtask

  // pulse start, then count cycles until done
  task automatic run_scan(output int cycles);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8 done cleared", {31'd0, done}, 32'd0);
    cycles = 0;
    while (!done && cycles < 200) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cyc;
    logic [31:0] held;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0;
    ent_words = '0; pend = '0; enab = '0; route_fiq = '0;
    repeat (3) @(negedge clk);
    check("R10 reset done", {31'd0, done}, 32'd0);
    check("R10 reset result", result, 32'h003F_003F);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 12; k++) begin
      load(VECS[k]);
      run_scan(cyc);
      check("R8 latency", cyc, 32'd40);
      check("R1-R7 vector result", result, VECS[k].expv);
      check("R11 zero bits", result & 32'h7FC0_7FC0, 32'd0);
    end

    // R9: inputs change after done, result and done must not
    held = result;
    pend = ALL; enab = ALL; route_fiq = '0;
    ent_words = '0; ent_words[31:0] = V | 32'd30;
    repeat (6) @(negedge clk);
    check("R9 held result", result, held);
    check("R9 held done", {31'd0, done}, 32'd1);

    // R8: restart during a scan
    load(VECS[3]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 mid-scan done low", {31'd0, done}, 32'd0);
    load(VECS[4]);
    run_scan(cyc);
    check("R8 restart latency", cyc, 32'd40);
    check("R3 restart result", result, 32'h800C_003F);

    // R8: back-to-back start keeps done low
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8 done low after start", {31'd0, done}, 32'd0);
    repeat (45) @(negedge clk);
    check("R8 done after rescan", {31'd0, done}, 32'd1);

    finish_run();
  end
endmodule